// File: doc/BRIEF.md
# Round-Robin Packet Merger with Length Insertion

This block gathers packets from several word-wide input streams and merges them into one output stream. Input ports take turns in round-robin order, and each turn carries exactly one whole packet. The block pulls the complete packet in before it sends anything. The first three words of a packet are a header and pass through unchanged. After the header the block sends one word that holds the payload length, and after that the payload words in their original order.

A packet that has fewer than four words, or more words than the payload store can hold, is still read in up to and including its last word. It then produces nothing on the output. A dropped packet still uses up its port's turn.

Every stream uses valid/ready handshaking, and a word moves only in a cycle where both valid and ready are high. On the input side, the block raises ready only on the port it is serving, and only while that port shows valid. On the output side, a low `out_ready` stalls the block. While stalled, `out_valid` stays high and `out_data` does not change until the word is taken.

Top module: `pkt_merge`

## Requirements
- R1: A synchronous active-high reset returns the block to idle, with `out_valid` low and every `in_ready` bit low. After reset, port 0 is the first port considered for service.
- R2: Each grant covers exactly one packet. When several ports have packets waiting, the output carries one packet from each in turn before any port gets a second turn.
- R3: After port p has been served, whether its packet was forwarded or dropped, the search for the next port starts at p+1 and wraps from NPORTS-1 to 0. Port p is considered last. Ports with no waiting data are passed over without spending a cycle on each one.
- R4: An accepted packet is sent as input words 0, 1 and 2 unchanged, then a length word, then input words 3 onward in input order.
- R5: The length word is the count of input words from index 3 up to and including the word marked by `in_last`, as an unsigned value zero-extended to the full word width.
- R6: A packet with fewer than 4 words is read in completely and produces no output words.
- R7: A packet of up to MAX_PAYLOAD+3 words is forwarded. A longer packet is read in completely and produces no output words.
- R8: At most one `in_ready` bit is high in any cycle, and an `in_ready` bit is never high while the matching `in_valid` bit is low.
- R9: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high with the same `out_data`. No word is lost or repeated.
- R10: No output word is offered in a cycle where an input word is being taken. The whole packet is buffered before its first word goes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NPORTS | Per-port word-present flag |
| in_ready | output | NPORTS | Per-port word-taken strobe |
| in_data | input | NPORTS*W | Packed per-port data, port p at bits [p*W +: W] |
| in_last | input | NPORTS | Per-port flag marking the final word of a packet |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Downstream can accept the word |
| out_data | output | W | Output word |

## Verification
A wrong round-robin pointer shows up right away as a packet from the wrong port. It appears on the first grant after the pointer was corrupted, which is at most one packet time later. A wrong header or payload counter shows up as a wrong length word, or as a shifted or missing payload word, and it does so within the same packet, because the length is produced before any payload. A wrong drop decision shows up in one of two ways: a short or long packet leaks onto the output, or a legal packet goes missing. Either way the total output word count for the run differs from the expected count. A controller that lost track of the packet boundary either stops raising `in_ready` or runs into the next packet. That leaves input words unread, or merges two packets under one header.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    ST_PICK = 2'd0,
    ST_RECV = 2'd1,
    ST_SEND = 2'd2
  } pm_state_e;
endpackage

// File: rtl/pm_rr_pick.sv
// Combinational round-robin search: first requesting port at or after start.
module pm_rr_pick #(
  parameter int NP = 4,
  parameter int PW = 2
) (
  input  logic [NP-1:0] req,
  input  logic [PW-1:0] start,
  output logic          hit,
  output logic [PW-1:0] sel
);
  logic [PW-1:0] cand;

  always_comb begin
    hit  = 1'b0;
    sel  = start;
    cand = start;
    for (int k = 0; k < NP; k++) begin
      cand = PW'((int'(start) + k) % NP);
      if (!hit && req[cand]) begin
        hit = 1'b1;
        sel = cand;
      end
    end
  end
endmodule

// File: rtl/pm_buf.sv
// Payload store: one write port, one asynchronous read port.
module pm_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_merge.sv
module pkt_merge #(
  parameter int NPORTS      = 4,
  parameter int W           = 16,
  parameter int MAX_PAYLOAD = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORTS-1:0]    in_valid,
  output logic [NPORTS-1:0]    in_ready,
  input  logic [NPORTS*W-1:0]  in_data,
  input  logic [NPORTS-1:0]    in_last,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_data
);
  import pm_pkg::*;

  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int LW = $clog2(MAX_PAYLOAD + 1);
  localparam int AW = (MAX_PAYLOAD > 1) ? $clog2(MAX_PAYLOAD) : 1;
  localparam int OW = $clog2(MAX_PAYLOAD + 4);

  pm_state_e     state;
  logic [PW-1:0] rr_ptr, cur, pick_sel, nxt_port;
  logic          pick_hit;
  logic [1:0]    hdr_cnt;
  logic [LW-1:0] plen;
  logic          over;
  logic [W-1:0]  hdr [0:2];
  logic [OW-1:0] oidx, last_idx;

  logic [W-1:0]  cur_data, buf_rdata;
  logic          cur_valid, cur_last, take, is_pay, buf_full, buf_we, drop;
  logic [AW-1:0] buf_raddr;

  pm_rr_pick #(.NP(NPORTS), .PW(PW)) u_pick (
    .req(in_valid), .start(rr_ptr), .hit(pick_hit), .sel(pick_sel)
  );

  pm_buf #(.W(W), .DEPTH(MAX_PAYLOAD), .AW(AW)) u_buf (
    .clk(clk), .rst(rst), .we(buf_we), .waddr(AW'(plen)), .wdata(cur_data),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  assign cur_data  = in_data[cur*W +: W];
  assign cur_valid = in_valid[cur];
  assign cur_last  = in_last[cur];
  assign take      = (state == ST_RECV) && cur_valid;
  assign is_pay    = (hdr_cnt == 2'd3);
  assign buf_full  = (plen == LW'(MAX_PAYLOAD));
  assign buf_we    = take && is_pay && !buf_full && !over;
  // decided on the last word: too short, or one payload word beyond the store
  assign drop      = !is_pay || over || buf_full;
  assign nxt_port  = (cur == PW'(NPORTS - 1)) ? '0 : cur + PW'(1);
  assign last_idx  = OW'(plen) + OW'(3);
  assign buf_raddr = (oidx >= OW'(4)) ? AW'(oidx - OW'(4)) : '0;

  always_comb begin
    in_ready = '0;
    if (take) in_ready[cur] = 1'b1;
  end

  assign out_valid = (state == ST_SEND);

  always_comb begin
    if (oidx < OW'(3))       out_data = hdr[oidx[1:0]];
    else if (oidx == OW'(3)) out_data = W'(plen);
    else                     out_data = buf_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_PICK;
      rr_ptr  <= '0;
      cur     <= '0;
      hdr_cnt <= '0;
      plen    <= '0;
      over    <= 1'b0;
      oidx    <= '0;
      for (int i = 0; i < 3; i++) hdr[i] <= '0;
    end else begin
      unique case (state)
        ST_PICK: begin
          if (pick_hit) begin
            cur     <= pick_sel;
            hdr_cnt <= '0;
            plen    <= '0;
            over    <= 1'b0;
            state   <= ST_RECV;
          end
        end
        ST_RECV: begin
          if (take) begin
            if (!is_pay) begin
              hdr[hdr_cnt] <= cur_data;
              hdr_cnt      <= hdr_cnt + 2'd1;
            end else if (buf_full) begin
              over <= 1'b1;
            end else if (!over) begin
              plen <= plen + LW'(1);
            end
            if (cur_last) begin
              if (drop) begin
                state  <= ST_PICK;
                rr_ptr <= nxt_port;
              end else begin
                state <= ST_SEND;
                oidx  <= '0;
              end
            end
          end
        end
        ST_SEND: begin
          if (out_ready) begin
            if (oidx == last_idx) begin
              state  <= ST_PICK;
              rr_ptr <= nxt_port;
            end else begin
              oidx <= oidx + OW'(1);
            end
          end
        end
        default: state <= ST_PICK;
      endcase
    end
  end
endmodule

// File: rtl/pm_check.sv
module pm_check #(
  parameter int NP = 4,
  parameter int W  = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [NP-1:0] in_valid,
  input logic [NP-1:0] in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && in_ready == '0));

  assert_ready_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~in_valid) == '0);

  assert_single_ready_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_send_while_reading_R10: assert property (@(posedge clk) disable iff (rst)
    (in_ready != '0) |-> !out_valid);
endmodule

bind pkt_merge pm_check #(.NP(NPORTS), .W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_pkt_merge.sv
module sim_pkt_merge;
  localparam int NP = 4;
  localparam int W  = 16;
  localparam int MB = 8;
  localparam int QD = 256;
  localparam int NSC = 5;

  // per scenario, per port: lengths of packet A and B (0 = none); row 4 is directed
  localparam int SC [NSC][NP][2] = '{
    '{'{5, 0}, '{0, 0}, '{7, 0}, '{4, 0}},
    '{'{6, 5}, '{0, 0}, '{9, 4}, '{11, 4}},
    '{'{3, 4}, '{12, 11}, '{1, 2}, '{15, 5}},
    '{'{4, 11}, '{7, 3}, '{13, 6}, '{5, 8}},
    '{'{5, 0}, '{5, 0}, '{5, 0}, '{5, 0}}
  };
  localparam bit SC_STALL [NSC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0, rst = 1'b1;
  logic [NP-1:0]   in_valid, in_ready, in_last;
  logic [NP*W-1:0] in_data;
  logic            out_valid, out_data_unused;
  logic            out_ready = 1'b1;
  logic [W-1:0]    out_data;

  logic [W-1:0] qdata [NP][QD];
  logic         qlast [NP][QD];
  int wr_cnt [NP];
  int rd_idx [NP];
  logic [W-1:0] exp_q [1024];
  logic [W-1:0] got_q [1024];
  int exp_n = 0, got_n = 0;
  int checks = 0, errors = 0;
  int stall_bad = 0, overlap_bad = 0, rdy_bad = 0;
  int model_ptr = 0;
  logic stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic prev_stall = 1'b0;
  logic [W-1:0] prev_data = '0;
  string tag [NSC] = '{"R4 R5", "R2 R3 R9", "R6 R7", "R2 R3 R9", "R1"};

  assign out_data_unused = 1'b0;

  pkt_merge #(.NPORTS(NP), .W(W), .MAX_PAYLOAD(MB)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      in_valid[p]        = (rd_idx[p] != wr_cnt[p]);
      in_data[p*W +: W]  = qdata[p][rd_idx[p] % QD];
      in_last[p]         = qlast[p][rd_idx[p] % QD];
    end
  end

  // input port model: pop on handshake
  initial begin
    for (int p = 0; p < NP; p++) rd_idx[p] = 0;
    forever begin
      @(posedge clk);
      for (int p = 0; p < NP; p++)
        if (in_ready[p] && in_valid[p]) rd_idx[p] <= rd_idx[p] + 1;
    end
  end

  // output readiness pattern
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // output monitor
  initial forever begin
    @(posedge clk);
    if (!rst) begin
      if (out_valid && out_ready) begin
        got_q[got_n % 1024] <= out_data;
        got_n <= got_n + 1;
      end
      if (prev_stall && !(out_valid && out_data == prev_data)) stall_bad <= stall_bad + 1;
      if ((in_ready != '0) && out_valid) overlap_bad <= overlap_bad + 1;
      if ((in_ready & ~in_valid) != '0) rdy_bad <= rdy_bad + 1;
      prev_stall <= out_valid && !out_ready;
      prev_data  <= out_data;
    end else begin
      prev_stall <= 1'b0;
    end
  end

  function automatic logic [W-1:0] word_of(int p, int s, int i);
    return {p[3:0], s[3:0], i[7:0]};
  endfunction

  task automatic push_exp(logic [W-1:0] v);
    exp_q[exp_n % 1024] = v;
    exp_n++;
  endtask

  task automatic load_and_model(int sc);
    int nw [NP];
    int taken [NP];
    bit any;
    for (int p = 0; p < NP; p++) begin
      nw[p] = wr_cnt[p];
      taken[p] = 0;
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < SC[sc][p][b]; i++) begin
          qdata[p][nw[p] % QD] = word_of(p, sc * 2 + b, i);
          qlast[p][nw[p] % QD] = (i == SC[sc][p][b] - 1);
          nw[p]++;
        end
      end
    end
    // packet-level round-robin model
    any = 1'b1;
    while (any) begin
      any = 1'b0;
      for (int k = 0; k < NP && !any; k++) begin
        int p, len;
        p = (model_ptr + k) % NP;
        if (taken[p] < 2 && SC[sc][p][taken[p]] != 0) begin
          any = 1'b1;
          len = SC[sc][p][taken[p]];
          if (len >= 4 && len <= MB + 3) begin
            for (int i = 0; i < 3; i++) push_exp(word_of(p, sc * 2 + taken[p], i));
            push_exp(W'(len - 3));
            for (int i = 3; i < len; i++) push_exp(word_of(p, sc * 2 + taken[p], i));
          end
          taken[p]++;
          model_ptr = (p + 1) % NP;
        end
      end
    end
    for (int p = 0; p < NP; p++) wr_cnt[p] = nw[p];
  endtask

  function automatic bit drained();
    for (int p = 0; p < NP; p++) if (rd_idx[p] != wr_cnt[p]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_scenario(int sc);
    int base, bad_at;
    bit done;
    base = exp_n;
    @(negedge clk);
    stall_en = SC_STALL[sc];
    load_and_model(sc);
    done = 1'b0;
    for (int t = 0; t < 4000 && !done; t++) begin
      @(negedge clk);
      done = (got_n >= exp_n) && drained();
    end
    repeat (20) @(negedge clk);
    stall_en = 1'b0;
    checks++;
    if (!done) begin
      errors++;
      $display("FAIL %s scenario %0d timeout: got %0d words expected %0d", tag[sc], sc, got_n, exp_n);
    end
    checks++;
    if (got_n != exp_n) begin
      errors++;
      $display("FAIL %s scenario %0d word count: actual %0d expected %0d", tag[sc], sc, got_n, exp_n);
    end
    bad_at = -1;
    for (int i = base; i < exp_n && i < got_n; i++)
      if (bad_at < 0 && got_q[i % 1024] != exp_q[i % 1024]) bad_at = i;
    checks++;
    if (bad_at >= 0) begin
      errors++;
      $display("FAIL %s scenario %0d word %0d: actual %h expected %h", tag[sc], sc,
               bad_at - base, got_q[bad_at % 1024], exp_q[bad_at % 1024]);
    end
    checks++;
    if (!drained()) begin
      errors++;
      $display("FAIL R6 R7 scenario %0d: input not fully consumed (actual 0 expected 1)", sc);
    end
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      wr_cnt[p] = 0;
      for (int i = 0; i < QD; i++) begin qdata[p][i] = '0; qlast[p][i] = 1'b0; end
    end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (out_valid !== 1'b0 || in_ready !== '0) begin
      errors++;
      $display("FAIL R1 reset state: actual valid=%b ready=%b expected valid=0 ready=0", out_valid, in_ready);
    end
    rst = 1'b0;

    for (int sc = 0; sc < 4; sc++) run_scenario(sc);

    checks++;  // R9
    if (stall_bad != 0) begin
      errors++; $display("FAIL R9 stall hold violations: actual %0d expected 0", stall_bad);
    end
    checks++;  // R10
    if (overlap_bad != 0) begin
      errors++; $display("FAIL R10 output during input: actual %0d expected 0", overlap_bad);
    end
    checks++;  // R8
    if (rdy_bad != 0) begin
      errors++; $display("FAIL R8 ready without valid: actual %0d expected 0", rdy_bad);
    end

    // directed R1: after a mid-run reset, port 0 is served first
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_ptr = 0;
    begin
      int base_r1;
      base_r1 = got_n;
      run_scenario(4);
      checks++;
      if (got_n <= base_r1 || got_q[base_r1 % 1024][W-1 -: 4] != 4'd0) begin
        errors++;
        $display("FAIL R1 first port after reset: actual %0d expected 0",
                 got_q[base_r1 % 1024][W-1 -: 4]);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung expected done)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule